// File: doc/BRIEF.md
# Phase-Detector Input Selector with Matched Prescalers

This block prepares the two clocks that a phase detector compares. On the reference side it picks one of two source clocks, a crystal-oscillator clock or an external reference clock, and divides it by 1, 2, 4 or 8. On the feedback side it picks either the clock returned by the internal loop divider or an externally looped-back clock, and divides it by the same ratio. Because one ratio code drives both dividers, routing a chip output back into the external feedback input makes the loop lock with output frequency equal to the reference frequency (zero-delay buffering).

All source clocks are sampled by a fast system clock `clk` through a two-flop synchroniser and the dividers count both edges of the chosen source, so every ratio, including divide by 1, keeps a 50% duty cycle. A change of source or ratio is never applied mid-phase: each path keeps running its current setting until a full low phase has elapsed, then restarts low under the new setting. The chosen ratio must bring the reference into the phase detector's 9.325 MHz to 94.5 MHz capture window; that range is a system constraint, not something the block checks.

Top module: `refsel_prescaler`

## Requirements
- R1: `src_sel` = 1 selects `xtal_clk` for the reference path and `src_sel` = 0 selects `ref_clk`; the unselected clock has no effect on `ref_div_out`.
- R2: `ratio_code` decodes as 2'b11 = divide by 1, 2'b10 = divide by 2, 2'b01 = divide by 4, 2'b00 = divide by 8 (bit 0 is the LSB); the divided output period is the ratio times the source period, high for exactly half of it.
- R3: The feedback divider always runs at the ratio given by the same `ratio_code` as the reference divider.
- R4: `fb_sel` = 1 selects `fb_int_clk` for the feedback path and `fb_sel` = 0 selects `fb_ext_clk`; the unselected clock has no effect on `fb_div_out`.
- R5: A new source or ratio is adopted by a path only at the end of a complete low phase of that path's output; no high or low phase is shorter than the shorter half-period of the old and new settings.
- R6: Synchronous active-high `rst` drives both outputs low, clears both dividers together and loads source and ratio directly from the pins; outputs stay low while `rst` is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock for the whole block |
| rst | input | 1 | Synchronous reset, active high |
| xtal_clk | input | 1 | Crystal-oscillator source clock |
| ref_clk | input | 1 | External reference source clock |
| fb_int_clk | input | 1 | Feedback clock from the internal loop divider |
| fb_ext_clk | input | 1 | Externally looped-back feedback clock |
| src_sel | input | 1 | Reference source select (1 crystal, 0 external) |
| fb_sel | input | 1 | Feedback source select (1 internal, 0 external) |
| ratio_code | input | 2 | Shared prescale ratio code |
| ref_div_out | output | 1 | Divided reference toward the phase detector |
| fb_div_out | output | 1 | Divided feedback toward the phase detector |

## Verification
The four source clocks run at four distinct periods (4, 6, 10 and 8 sampling cycles), so a measured output period identifies both which source was taken and which ratio was applied; eight settings cover every select combination and every ratio code on both paths at once. Measuring the high time separately from the period tells a 50% divider from one that only gets the frequency right. A switch from a fast setting to a slow one is watched run by run to catch any runt pulse, and a mid-run reset with sources still toggling shows that both outputs are held low.

// File: rtl/refsel_prescaler.sv
module refsel_prescaler #(
  parameter int CODE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              xtal_clk,
  input  logic              ref_clk,
  input  logic              fb_int_clk,
  input  logic              fb_ext_clk,
  input  logic              src_sel,
  input  logic              fb_sel,
  input  logic [CODE_W-1:0] ratio_code,
  output logic              ref_div_out,
  output logic              fb_div_out
);
  localparam int MAX_DIV = 1 << ((1 << CODE_W) - 1);
  localparam int CNT_W   = (MAX_DIV > 1) ? $clog2(MAX_DIV) : 1;

  logic [3:0] raw, sync1, sync2, sync3;
  logic [1:0] pin_sel;
  logic [1:0] div_bus, edge_bus, sel_bus;
  logic [2*CODE_W-1:0] code_bus;

  assign raw     = {fb_ext_clk, fb_int_clk, ref_clk, xtal_clk};
  assign pin_sel = {fb_sel, src_sel};

  always_ff @(posedge clk) begin
    sync1 <= raw;
    sync2 <= sync1;
    sync3 <= sync2;
  end

  for (genvar p = 0; p < 2; p++) begin : g_path
    logic              sel_q;
    logic [CODE_W-1:0] code_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              out_q;
    logic              cur, prv, pending;
    logic [CNT_W-1:0]  last;

    assign cur     = sel_q ? sync2[2*p] : sync2[2*p+1];
    assign prv     = sel_q ? sync3[2*p] : sync3[2*p+1];
    assign last    = CNT_W'((MAX_DIV >> code_q) - 1);
    assign pending = (pin_sel[p] != sel_q) || (ratio_code != code_q);

    always_ff @(posedge clk) begin
      if (rst) begin
        sel_q  <= pin_sel[p];
        code_q <= ratio_code;
        cnt_q  <= '0;
        out_q  <= 1'b0;
      end else if (cur ^ prv) begin
        if (cnt_q == last) begin
          cnt_q <= '0;
          if (!out_q && pending) begin
            sel_q  <= pin_sel[p];
            code_q <= ratio_code;
          end else begin
            out_q <= ~out_q;
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end

    assign div_bus[p]                   = out_q;
    assign edge_bus[p]                  = cur ^ prv;
    assign sel_bus[p]                   = sel_q;
    assign code_bus[p*CODE_W +: CODE_W] = code_q;
  end

  assign ref_div_out = div_bus[0];
  assign fb_div_out  = div_bus[1];
endmodule

module refsel_prescaler_chk #(
  parameter int CODE_W = 2
) (
  input logic                clk,
  input logic                rst,
  input logic                src_sel,
  input logic                fb_sel,
  input logic [CODE_W-1:0]   ratio_code,
  input logic                ref_div_out,
  input logic                fb_div_out,
  input logic [1:0]          edge_bus,
  input logic [1:0]          sel_bus,
  input logic [2*CODE_W-1:0] code_bus
);
  AST_RST_OUTPUTS_LOW: assert property (@(posedge clk)
    rst |=> (!ref_div_out && !fb_div_out)); // R6

  AST_RST_LOADS_PINS: assert property (@(posedge clk)
    rst |=> (sel_bus == $past({fb_sel, src_sel}) &&
             code_bus == {2{$past(ratio_code)}})); // R6

  AST_REF_SWITCH_IN_LOW: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (!$stable(code_bus[CODE_W-1:0]) || !$stable(sel_bus[0])))
      |-> (!ref_div_out && !$past(ref_div_out))); // R5

  AST_FB_SWITCH_IN_LOW: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (!$stable(code_bus[2*CODE_W-1:CODE_W]) || !$stable(sel_bus[1])))
      |-> (!fb_div_out && !$past(fb_div_out))); // R5

  AST_FB_CODE_FROM_SHARED_PINS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(code_bus[2*CODE_W-1:CODE_W]))
      |-> (code_bus[2*CODE_W-1:CODE_W] == $past(ratio_code))); // R3

  AST_REF_TOGGLE_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(ref_div_out)) |-> $past(edge_bus[0])); // R2

  AST_FB_TOGGLE_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(fb_div_out)) |-> $past(edge_bus[1])); // R4
endmodule

bind refsel_prescaler refsel_prescaler_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst(rst), .src_sel(src_sel), .fb_sel(fb_sel),
  .ratio_code(ratio_code), .ref_div_out(ref_div_out), .fb_div_out(fb_div_out),
  .edge_bus(edge_bus), .sel_bus(sel_bus), .code_bus(code_bus)
);

// File: tb/refsel_prescaler_bench.sv
module refsel_prescaler_bench;
  localparam int H_X = 2, H_R = 3, H_I = 5, H_E = 4;
  localparam int NV = 8;
  // src_sel, fb_sel, ratio_code, expected ref period, expected fb period
  localparam int VEC [NV][5] = '{
    '{1, 1, 3,  4, 10},
    '{0, 1, 3,  6, 10},
    '{1, 0, 2,  8, 16},
    '{0, 0, 1, 24, 32},
    '{1, 1, 0, 32, 80},
    '{0, 0, 0, 48, 64},
    '{1, 0, 1, 16, 32},
    '{0, 1, 2, 12, 20}
  };

  logic clk = 0, rst = 1;
  logic xtal_clk = 0, ref_clk = 0, fb_int_clk = 0, fb_ext_clk = 0;
  logic src_sel = 1, fb_sel = 1;
  logic [1:0] ratio_code = 2'b11;
  logic ref_div_out, fb_div_out;
  int checks = 0, errors = 0, cyc = 0;

  refsel_prescaler u_refsel_prescaler (.*);

  always #10 clk = ~clk;

  int cx = 0, cr = 0, ci = 0, ce = 0;
  always @(negedge clk) begin
    cx <= (cx == H_X - 1) ? 0 : cx + 1; if (cx == H_X - 1) xtal_clk   <= ~xtal_clk;
    cr <= (cr == H_R - 1) ? 0 : cr + 1; if (cr == H_R - 1) ref_clk    <= ~ref_clk;
    ci <= (ci == H_I - 1) ? 0 : ci + 1; if (ci == H_I - 1) fb_int_clk <= ~fb_int_clk;
    ce <= (ce == H_E - 1) ? 0 : ce + 1; if (ce == H_E - 1) fb_ext_clk <= ~fb_ext_clk;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic get(input int path);
    return (path == 0) ? ref_div_out : fb_div_out;
  endfunction

  task automatic wait_rise(input int path);
    logic p;
    p = get(path);
    forever begin
      @(negedge clk);
      if (!p && get(path)) break;
      p = get(path);
    end
  endtask

  task automatic measure(input int path, output int per, output int hi);
    logic p;
    wait_rise(path);
    wait_rise(path);
    per = 0; hi = 0;
    do begin
      if (get(path)) hi++;
      per++;
      p = get(path);
      @(negedge clk);
    end while (!(!p && get(path)));
  endtask

  logic mon_en = 0;
  logic last_r, last_f, st_r, st_f;
  int len_r, len_f, min_r, min_f;
  always @(negedge clk) begin
    if (!mon_en) begin
      last_r <= ref_div_out; last_f <= fb_div_out;
      len_r <= 0; len_f <= 0; st_r <= 0; st_f <= 0;
      min_r <= 1000; min_f <= 1000;
    end else begin
      if (ref_div_out == last_r) len_r <= len_r + 1;
      else begin
        if (st_r && len_r < min_r) min_r <= len_r;
        st_r <= 1; len_r <= 1; last_r <= ref_div_out;
      end
      if (fb_div_out == last_f) len_f <= len_f + 1;
      else begin
        if (st_f && len_f < min_f) min_f <= len_f;
        st_f <= 1; len_f <= 1; last_f <= fb_div_out;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog (all requirements) actual=%0d expected=<150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int per, hi, highs;
    repeat (6) @(negedge clk);
    chk("R6 ref low in reset", ref_div_out, 0);
    chk("R6 fb low in reset", fb_div_out, 0);
    rst = 0;

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      src_sel = VEC[v][0][0];
      fb_sel = VEC[v][1][0];
      ratio_code = VEC[v][2][1:0];
      measure(0, per, hi);
      chk($sformatf("R1/R2 ref period row %0d", v), per, VEC[v][3]);
      chk($sformatf("R2 ref high time row %0d", v), hi, VEC[v][3] / 2);
      measure(1, per, hi);
      chk($sformatf("R3/R4 fb period row %0d", v), per, VEC[v][4]);
      chk($sformatf("R3 fb high time row %0d", v), hi, VEC[v][4] / 2);
    end

    // R6: reset mid-run while sources keep toggling
    @(negedge clk); rst = 1;
    @(negedge clk);
    highs = 0;
    repeat (40) begin
      @(negedge clk);
      if (ref_div_out || fb_div_out) highs++;
    end
    chk("R6 outputs held low during reset", highs, 0);
    rst = 0;

    // R5: fast setting to slow setting, watch every phase
    src_sel = 1; fb_sel = 1; ratio_code = 2'b10;
    measure(0, per, hi);
    chk("R5 pre-switch ref period", per, 8);
    mon_en = 1;
    repeat (5) @(negedge clk);
    src_sel = 0; ratio_code = 2'b00;
    measure(0, per, hi);
    chk("R5 post-switch ref period", per, 48);
    repeat (100) @(negedge clk);
    chk("R5 no ref runt phase", (min_r >= 4) ? 1 : 0, 1);
    chk("R5 no fb runt phase", (min_f >= 10) ? 1 : 0, 1);
    mon_en = 0;

    // R5: slow back to fast, then R1 unselected source ignored
    @(negedge clk);
    mon_en = 1;
    src_sel = 1; ratio_code = 2'b11;
    measure(0, per, hi);
    chk("R1 ref back on crystal div1 period", per, 4);
    repeat (50) @(negedge clk);
    chk("R5 no ref runt on return", (min_r >= 2) ? 1 : 0, 1);
    mon_en = 0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule